// File: doc/BRIEF.md
# Quasi-Bidirectional Port

This block is an 8-bit general-purpose port for a microcontroller core. It has no direction register. A single output latch, written over the core's internal bus, sets the role of each pin. A latch bit of 0 turns on a strong pull-down, so the pin is driven low. A latch bit of 1 turns the pull-down off, and the pin is then held high only by a weak pull-up. An outside device can overdrive that weak high, which is how the pin is used as an input.

The port has two read paths, chosen with a select input. The latch path returns what was last written. The pin path returns the level on the pad after a two-flop synchronizer. Read-modify-write sequences use the latch path, so a pin that an outside device holds low does not lose its latch bit.

A build parameter selects an open-drain variant. In that variant there is no weak pull-up at all, and a latch 1 leaves the pin floating. The pad itself is modelled outside the block. The block only produces the two enables for each bit and takes the pad level back in.

Top module: `qbio_port`

## Requirements
- R1: While reset is asserted and after it is released, before any write, every latch bit is 1. Reading the latch (`rd_pin_sel`=0) at the port address returns all ones, `pad_pd_en` is all zeros and, in the weak pull-up variant, `pad_pu_en` is all ones.
- R2: A write updates the latch with `bus_wdata` on the rising clock edge where `bus_wr`=1 and `bus_addr` equals `PORT_ADDR`. The new value shows at the outputs after that edge. A write strobe with any other address, or a cycle with `bus_wr`=0, leaves the latch unchanged.
- R3: Latch bit n = 0 sets `pad_pd_en[n]`=1 and `pad_pu_en[n]`=0.
- R4: Latch bit n = 1 sets `pad_pd_en[n]`=0. In the weak pull-up variant (`OPEN_DRAIN`=0) it also sets `pad_pu_en[n]`=1. The port never drives a strong high.
- R5: With `OPEN_DRAIN`=1, `pad_pu_en` is always zero. A pin whose latch bit is 1 is undriven, so its pin read follows whatever level the pad floats to.
- R6: With `rd_pin_sel`=0 at the port address, `bus_rdata` returns the latch contents, whatever level the pins carry.
- R7: With `rd_pin_sel`=1 at the port address, `bus_rdata` returns `pad_in` through two flops. A pad level that is stable before rising edge k shows on `bus_rdata` after edge k+1, and not after edge k alone. Both synchronizer flops reset to all ones.
- R8: When `bus_addr` differs from `PORT_ADDR`, `bus_rdata` is all zeros for either read path.
- R9: For no bit are `pad_pd_en` and `pad_pu_en` asserted together.
- R10: A read-modify-write that reads the latch path and writes back the modified value keeps a 1 in every unmodified latch bit, even when an outside device holds that pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address from the core bus |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| rd_pin_sel | input | 1 | Read source: 0 returns the latch, 1 returns the synchronized pin level |
| bus_rdata | output | WIDTH | Read data, zero when the address does not match |
| pad_in | input | WIDTH | Level seen on the pads |
| pad_pd_en | output | WIDTH | Strong pull-down enable for each bit |
| pad_pu_en | output | WIDTH | Weak pull-up enable for each bit |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable around each rising edge. They also assume that `pad_in` is a level the synchronizer samples on the same clock, so that it matches the value from two edges earlier once two clean edges have passed after reset. The bench changes every input one nanosecond after a rising edge and reads outputs on the falling edge. The pad model never drives a pin high against an active pull-down: an external device only pulls a pin low, or lets go of it. Floating pins in the open-drain instance are given a fixed level by the bench, so the pin reads there are defined.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

  typedef enum logic {
    RD_LATCH = 1'b0,
    RD_PIN   = 1'b1
  } rd_src_e;

  // strong pull-down is on exactly when the latch bit is clear
  function automatic logic pull_down_on(input logic latch_bit);
    return ~latch_bit;
  endfunction

  // weak pull-up follows a set latch bit unless the port is open-drain
  function automatic logic weak_up_on(input logic latch_bit, input logic open_drain);
    return open_drain ? 1'b0 : latch_bit;
  endfunction

endpackage

// File: rtl/qbio_latch.sv
module qbio_latch #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [WIDTH-1:0]  wdata,
  output logic              addr_hit,
  output logic [WIDTH-1:0]  latch_q
);

  localparam logic [WIDTH-1:0] RESET_VAL = '1;

  logic wr_hit;

  assign addr_hit = (addr == PORT_ADDR);
  assign wr_hit   = wr & addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= RESET_VAL;
    else if (wr_hit) latch_q <= wdata;
  end

  // R2
  write_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PORT_ADDR) |=> (latch_q == $past(wdata)));

  // R2
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == PORT_ADDR) |=> $stable(latch_q));

endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_q
);

  localparam logic [STAGES-1:0][WIDTH-1:0] RESET_VAL = '1;

  logic [STAGES-1:0][WIDTH-1:0] stg;
  logic [1:0]                   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= RESET_VAL;
    else        stg <= {stg[STAGES-2:0], pad_in};
  end

  assign pin_q = stg[STAGES-1];

  // counts clean edges since reset, saturating, for the latency check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      // R7
      sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (pin_q == $past(pad_in, 2)));
    end
  endgenerate

endmodule

// File: rtl/qbio_drive.sv
module qbio_drive #(
  parameter int WIDTH = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] pu_en
);
  import qbio_pkg::*;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign pd_en[i] = pull_down_on(latch_q[i]);
      assign pu_en[i] = weak_up_on(latch_q[i], OPEN_DRAIN);
    end
  endgenerate

  // R9
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & pu_en) == '0);

  generate
    if (OPEN_DRAIN) begin : g_od_chk
      // R5
      od_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_en == '0);
    end
  endgenerate

endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h90,
  parameter bit OPEN_DRAIN = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              rd_pin_sel,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_pd_en,
  output logic [WIDTH-1:0]  pad_pu_en
);
  import qbio_pkg::*;

  logic             addr_hit;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_q;
  rd_src_e          rd_src;

  qbio_latch #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_latch (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .addr_hit(addr_hit), .latch_q(latch_q)
  );

  qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_q(pin_q)
  );

  qbio_drive #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_drive (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .pd_en(pad_pd_en), .pu_en(pad_pu_en)
  );

  assign rd_src = rd_src_e'(rd_pin_sel);

  always_comb begin
    bus_rdata = '0;
    if (addr_hit) bus_rdata = (rd_src == RD_PIN) ? pin_q : latch_q;
  end

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != PORT_ADDR) |-> (bus_rdata == '0));

  // R6
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == PORT_ADDR && !rd_pin_sel) |-> (bus_rdata == ~pad_pd_en));

endmodule

// File: tb/qbio_port_tb.sv
module qbio_port_tb;

  localparam int W = 8;
  localparam logic [7:0] PA = 8'h90;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = PA;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       rd_pin_sel = 1'b0;
  logic [7:0] rdata, rdata_od, pd, pu, pd_od, pu_od;
  logic [7:0] pad_q, pad_od;
  logic [7:0] ext_en = '0;
  logic [7:0] ext_val = '0;
  logic [7:0] float_val = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  sb_item_t sbq[$];

  always #2 clk = ~clk;

  qbio_port #(.PORT_ADDR(PA), .OPEN_DRAIN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_pin_sel(rd_pin_sel), .bus_rdata(rdata),
    .pad_in(pad_q), .pad_pd_en(pd), .pad_pu_en(pu)
  );

  qbio_port #(.PORT_ADDR(PA), .OPEN_DRAIN(1'b1)) u_dut_od (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_pin_sel(rd_pin_sel), .bus_rdata(rdata_od),
    .pad_in(pad_od), .pad_pd_en(pd_od), .pad_pu_en(pu_od)
  );

  // pad model: outside driver wins, then strong low, then weak high, else floating level
  always_comb begin
    for (int i = 0; i < W; i++) begin
      pad_q[i]  = ext_en[i] ? ext_val[i] : (pd[i] ? 1'b0 : (pu[i] ? 1'b1 : float_val[i]));
      pad_od[i] = ext_en[i] ? ext_val[i] : (pd_od[i] ? 1'b0 : (pu_od[i] ? 1'b1 : float_val[i]));
    end
  end

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = pd;
        2: act = pu;
        3: act = rdata_od;
        4: act = pu_od;
        5: act = pd_od;
        default: act = pd & pu;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = PA;
  endtask

  // sets address and read source after an edge, queues the expectation
  task automatic rd(input logic [7:0] a, input logic sel, input int kind,
                    input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    bus_addr = a; rd_pin_sel = sel;
    push(kind, exp, req);
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    // R1: state while reset is held
    #1; push(1, 8'h00, "R1"); push(2, 8'hFF, "R1");
    #1; @(negedge clk); #1;
    idle(2); rst_n = 1'b1;
    rd(PA, 1'b0, 0, 8'hFF, "R1");
    rd(PA, 1'b0, 1, 8'h00, "R1");
    rd(PA, 1'b0, 2, 8'hFF, "R1");
    rd(PA, 1'b1, 0, 8'hFF, "R7 reset/pulled high");
    rd(PA, 1'b0, 4, 8'h00, "R5");

    // R2 R3 R4 R5: write a pattern
    wr(PA, 8'hA5);
    rd(PA, 1'b0, 0, 8'hA5, "R2");
    rd(PA, 1'b0, 1, 8'h5A, "R3");
    rd(PA, 1'b0, 2, 8'hA5, "R4");
    rd(PA, 1'b0, 4, 8'h00, "R5");
    rd(PA, 1'b0, 5, 8'h5A, "R3 od");
    rd(PA, 1'b0, 6, 8'h00, "R9");

    // R2: wrong address and no strobe leave latch alone
    wr(8'h80, 8'h00);
    rd(PA, 1'b0, 0, 8'hA5, "R2 other addr");
    @(posedge clk); #1; bus_wdata = 8'h3C; bus_wr = 1'b0;
    rd(PA, 1'b0, 0, 8'hA5, "R2 no strobe");

    // R8: miss reads zero
    rd(8'h91, 1'b0, 0, 8'h00, "R8 latch");
    rd(8'h91, 1'b1, 0, 8'h00, "R8 pin");

    // R7: pin level through synchronizer; R5 floating pins read float level
    idle(3);
    rd(PA, 1'b1, 0, 8'hA5, "R7");
    rd(PA, 1'b1, 3, 8'h00, "R5 floating");
    float_val = 8'hFF;
    idle(3);
    rd(PA, 1'b1, 3, 8'hA5, "R5 floating high");
    float_val = 8'h00;

    // R7 latency: external pulls bit 0 low right after an edge
    wr(PA, 8'hFF);
    idle(3);
    rd(PA, 1'b1, 0, 8'hFF, "R7 before");
    ext_en = 8'h01; ext_val = 8'h00;
    rd(PA, 1'b1, 0, 8'hFF, "R7 one edge");
    rd(PA, 1'b1, 0, 8'hFE, "R7 two edges");

    // R6: latch read ignores the pin held low
    rd(PA, 1'b0, 0, 8'hFF, "R6");
    rd(PA, 1'b0, 6, 8'h00, "R9");

    // R10: read-modify-write clearing bit 7 via latch path
    @(posedge clk); #1; bus_addr = PA; rd_pin_sel = 1'b0;
    @(negedge clk); snap = rdata; #1;
    wr(PA, snap & 8'h7F);
    rd(PA, 1'b0, 0, 8'h7F, "R10");
    rd(PA, 1'b0, 1, 8'h80, "R10");
    ext_en = '0;

    // R3 R4: another pattern
    wr(PA, 8'h0F);
    rd(PA, 1'b0, 1, 8'hF0, "R3");
    rd(PA, 1'b0, 2, 8'h0F, "R4");
    rd(PA, 1'b0, 6, 8'h00, "R9");

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule